// File: doc/BRIEF.md
# Comparator Edge Interrupt Controller

This block gathers interrupt events from three comparator channels. Each channel receives a comparator result bit that changes asynchronously to the clock. The block resynchronizes that bit and can invert it with a per-channel polarity control. It then watches the resulting output for a transition of the kind chosen by that channel's two-bit event mode. A qualifying transition sets a sticky per-channel flag. Software can clear any flag by writing 0 or force it by writing 1.

A single interrupt request is raised from the flags. It is active when at least one flagged channel has its channel enable set, and both the peripheral enable and the global enable are set. The enables only gate the request. A flag still records its event while every enable is off. The three polarity-adjusted outputs are exposed on a status bus. In any-change mode, software can compare that bus against a saved copy to learn which way the output moved.

All pins are plain control and status signals. The block moves no data stream, so there is no handshake at its edge.

Top module: `cmp_edge_irq_ctrl`

## Requirements
- R1: Event mode code 2'b00 never sets that channel's flag, whatever the comparator or polarity does.
- R2: Event mode code 2'b01 sets the flag when the adjusted output goes from 0 to 1.
- R3: Event mode code 2'b10 sets the flag when the adjusted output goes from 1 to 0.
- R4: Event mode code 2'b11 sets the flag on every change of the adjusted output.
- R5: The adjusted output equals the synchronized comparator bit XOR the channel's polarity bit. It appears on `status_o` (bit i is channel i), and edges are judged on it, so inversion swaps which raw crossing qualifies.
- R6: Toggling a polarity bit is itself a transition of the adjusted output and sets the flag when the active mode accepts that direction.
- R7: A set flag stays set until a write (`flag_wr_en`=1) carries 0 in its bit position. A write of 0 clears it on the next clock.
- R8: A write with 1 in a flag's bit position sets that flag on the next clock.
- R9: When a qualifying event and a write of 0 hit the same flag in the same cycle, the flag ends up set.
- R10: `irq_o` is combinational and equals global_en AND periph_en AND OR over i of (flag[i] AND ch_en[i]).
- R11: Flags latch qualifying events while any or all enables are 0.
- R12: A change of `cmp_raw` shows on `status_o` after two rising clock edges, and the resulting flag is set on the third edge.
- R13: After reset all flags are 0, the synchronizers and previous-output registers hold 0, and `irq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_raw | input | NCH | Asynchronous comparator result bits |
| pol | input | NCH | Per-channel output inversion |
| mode | input | 2*NCH | Per-channel event mode, bits [2i+1:2i] for channel i |
| flag_wr_en | input | 1 | Write strobe for the flag register |
| flag_wr_data | input | NCH | Value written to the flags |
| ch_en | input | NCH | Per-channel interrupt enables |
| periph_en | input | 1 | Peripheral interrupt enable |
| global_en | input | 1 | Global interrupt enable |
| flag_o | output | NCH | Sticky interrupt flags |
| status_o | output | NCH | Polarity-adjusted comparator outputs |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench covers several corner cases. It forces a polarity toggle in the same cycle as a clearing write; a design where the write wins would lose the event and leave the flag at 0. It drives raw transitions under inverted polarity in rising and falling modes; a design that detects edges before inversion would flag the wrong direction. It holds all enables low during events; a design that gates the flags rather than the request would leave them clear. It also counts edges from a raw change to the status and flag outputs, so a missing or extra synchronizer stage shows up as a one-cycle shift against the bench model.

// File: rtl/cmpirq_pkg.sv
package cmpirq_pkg;
  typedef enum logic [1:0] {
    EV_OFF  = 2'b00,
    EV_RISE = 2'b01,
    EV_FALL = 2'b10,
    EV_ANY  = 2'b11
  } ev_mode_e;
endpackage

// File: rtl/cmpirq_sync.sv
module cmpirq_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) chain[0] <= '0;
    else        chain[0] <= d_async;
  end

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rst_n) chain[s] <= '0;
        else        chain[s] <= chain[s-1];
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/cmpirq_edge.sv
module cmpirq_edge
  import cmpirq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sync_bit,
  input  logic       pol,
  input  logic [1:0] mode,
  output logic       adj,
  output logic       ev
);
  logic prev_q;
  logic rise, fall;

  assign adj  = sync_bit ^ pol;
  assign rise = adj & ~prev_q;
  assign fall = ~adj & prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= adj;
  end

  always_comb begin
    unique case (ev_mode_e'(mode))
      EV_OFF:  ev = 1'b0;
      EV_RISE: ev = rise;
      EV_FALL: ev = fall;
      EV_ANY:  ev = rise | fall;
      default: ev = 1'b0;
    endcase
  end

  // R6
  pol_toggle_any_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b11 && $stable(sync_bit) && $changed(pol)) |-> ev);
endmodule

// File: rtl/cmpirq_flags.sv
module cmpirq_flags #(
  parameter int NCH = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] ev,
  input  logic           wr_en,
  input  logic [NCH-1:0] wr_data,
  output logic [NCH-1:0] flags
);
  generate
    for (genvar i = 0; i < NCH; i++) begin : g_flag
      logic base;
      assign base = wr_en ? wr_data[i] : flags[i];
      always_ff @(posedge clk) begin
        if (!rst_n) flags[i] <= 1'b0;
        else        flags[i] <= base | ev[i];
      end

      // R9
      hw_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev[i] |=> flags[i]);
      // R7
      sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[i] && !(wr_en && !wr_data[i])) |=> flags[i]);
      // R7
      clear_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_data[i] && !ev[i]) |=> !flags[i]);
      // R8
      force_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[i]) |=> flags[i]);
    end
  endgenerate
endmodule

// File: rtl/cmpirq_gate.sv
module cmpirq_gate #(
  parameter int NCH = 3
) (
  input  logic [NCH-1:0] flags,
  input  logic [NCH-1:0] ch_en,
  input  logic           periph_en,
  input  logic           global_en,
  output logic           irq
);
  assign irq = (|(flags & ch_en)) & periph_en & global_en;
endmodule

// File: rtl/cmp_edge_irq_ctrl.sv
module cmp_edge_irq_ctrl #(
  parameter int NCH         = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   cmp_raw,
  input  logic [NCH-1:0]   pol,
  input  logic [2*NCH-1:0] mode,
  input  logic             flag_wr_en,
  input  logic [NCH-1:0]   flag_wr_data,
  input  logic [NCH-1:0]   ch_en,
  input  logic             periph_en,
  input  logic             global_en,
  output logic [NCH-1:0]   flag_o,
  output logic [NCH-1:0]   status_o,
  output logic             irq_o
);
  logic [NCH-1:0] cmp_sync;
  logic [NCH-1:0] ev;

  cmpirq_sync #(.W(NCH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(cmp_raw), .q_sync(cmp_sync)
  );

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_ch
      cmpirq_edge u_edge (
        .clk(clk), .rst_n(rst_n), .sync_bit(cmp_sync[i]), .pol(pol[i]),
        .mode(mode[2*i +: 2]), .adj(status_o[i]), .ev(ev[i])
      );

      // R1
      mode_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode[2*i +: 2] == 2'b00) |-> !ev[i]);
      // R11
      latch_when_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev[i] && !global_en && !periph_en) |=> flag_o[i]);
    end
  endgenerate

  cmpirq_flags #(.NCH(NCH)) u_flags (
    .clk(clk), .rst_n(rst_n), .ev(ev), .wr_en(flag_wr_en),
    .wr_data(flag_wr_data), .flags(flag_o)
  );

  cmpirq_gate #(.NCH(NCH)) u_gate (
    .flags(flag_o), .ch_en(ch_en), .periph_en(periph_en),
    .global_en(global_en), .irq(irq_o)
  );

  // R10
  irq_needs_enables_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (global_en && periph_en && (|(flag_o & ch_en))));
  // R13
  reset_clears_chk: assert property (@(posedge clk)
    !rst_n |=> (flag_o == '0 && !irq_o));
endmodule

// File: tb/cmp_edge_irq_ctrl_tb.sv
`timescale 1ns/1ps
module cmp_edge_irq_ctrl_tb_top;
  localparam int NCH = 3;

  logic clk = 0, rst_n = 0;
  logic [NCH-1:0] cmp_raw = 0, pol = 0, flag_wr_data = 0, ch_en = 0;
  logic [2*NCH-1:0] mode = 0;
  logic flag_wr_en = 0, periph_en = 0, global_en = 0;
  logic [NCH-1:0] flag_o, status_o;
  logic irq_o;

  int n_chk = 0, n_bad = 0;
  string cur_tag = "R13";
  bit cmp_on = 0;

  always #2.5 clk = ~clk;

  cmp_edge_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cmp_raw(cmp_raw), .pol(pol), .mode(mode),
    .flag_wr_en(flag_wr_en), .flag_wr_data(flag_wr_data), .ch_en(ch_en),
    .periph_en(periph_en), .global_en(global_en),
    .flag_o(flag_o), .status_o(status_o), .irq_o(irq_o)
  );

  // Reference model built from the requirements
  logic [NCH-1:0] m_s1, m_s2, m_prev, m_flag, m_adj, m_ev;

  function automatic logic qual(input logic [1:0] md, input logic pv, input logic cu);
    case (md)
      2'b01:   return cu & ~pv;
      2'b10:   return ~cu & pv;
      2'b11:   return cu ^ pv;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic exp_irq(input logic [NCH-1:0] f);
    return global_en & periph_en & (|(f & ch_en));
  endfunction

  always_comb begin
    m_adj = m_s2 ^ pol;
    for (int i = 0; i < NCH; i++) m_ev[i] = qual(mode[2*i +: 2], m_prev[i], m_adj[i]);
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 <= 0; m_s2 <= 0; m_prev <= 0; m_flag <= 0;
    end else begin
      m_s1 <= cmp_raw; m_s2 <= m_s1; m_prev <= m_adj;
      m_flag <= (flag_wr_en ? flag_wr_data : m_flag) | m_ev;
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (cmp_on && rst_n) begin
      chk({cur_tag, " flags"}, 32'(flag_o), 32'(m_flag));
      chk({cur_tag, " status R5"}, 32'(status_o), 32'(m_adj));
      chk({cur_tag, " irq R10"}, 32'(irq_o), 32'(exp_irq(m_flag)));
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [NCH-1:0] v);
    @(negedge clk); flag_wr_en = 1; flag_wr_data = v;
    @(negedge clk); flag_wr_en = 0;
  endtask

  // watchdog
  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5678));
    cyc(3);
    rst_n = 1;
    @(posedge clk); #1;
    chk("R13 flags", 32'(flag_o), 0);
    chk("R13 irq", 32'(irq_o), 0);
    chk("R13 status", 32'(status_o), 0);
    cmp_on = 1;

    // R1: mode off, toggles of raw and polarity
    cur_tag = "R1"; mode = 6'b00_00_00;
    @(negedge clk); cmp_raw = 3'b111; cyc(4); pol = 3'b101; cyc(2); cmp_raw = 0; cyc(4);
    chk("R1 no flag", 32'(flag_o), 0);
    pol = 0; cyc(4); wr(0); cyc(1);

    // R12 + R2: latency on channel 0, rising mode
    cur_tag = "R2"; mode = 6'b01_01_01;
    @(negedge clk); cmp_raw = 3'b001;
    @(posedge clk); #1; chk("R12 status after 1 edge", 32'(status_o), 0);
    @(posedge clk); #1; chk("R12 status after 2 edges", 32'(status_o), 1);
    chk("R12 flag after 2 edges", 32'(flag_o), 0);
    @(posedge clk); #1; chk("R2/R12 flag after 3 edges", 32'(flag_o), 1);
    // R3: falling does not set under rising mode, then falling mode
    wr(0); cmp_raw = 0; cyc(4);
    chk("R2 falling ignored", 32'(flag_o), 0);
    cur_tag = "R3"; mode = 6'b10_10_10;
    cmp_raw = 3'b010; cyc(4); chk("R3 rise ignored", 32'(flag_o), 0);
    cmp_raw = 0; cyc(4); chk("R3 fall sets", 32'(flag_o), 3'b010);
    wr(0);

    // R4: any change
    cur_tag = "R4"; mode = 6'b11_11_11;
    @(negedge clk); cmp_raw = 3'b100; cyc(4); chk("R4 rise", 32'(flag_o), 3'b100);
    wr(0); cmp_raw = 0; cyc(4); chk("R4 fall", 32'(flag_o), 3'b100);
    wr(0); cyc(2);

    // R5: inverted polarity in rising mode; raw fall gives adjusted rise
    cur_tag = "R5"; mode = 6'b00_00_01; cmp_raw = 3'b001; cyc(4); wr(0);
    pol = 3'b001; cyc(3); wr(0); cyc(2);
    chk("R5 status inverted", 32'(status_o), 0);
    cmp_raw = 0; cyc(4); chk("R5 raw fall sets under inversion", 32'(flag_o), 1);
    wr(0); pol = 0; cyc(3); wr(0);

    // R6: polarity toggle counts as transition
    cur_tag = "R6"; mode = 6'b11_00_00; cyc(2);
    pol = 3'b100; cyc(2); chk("R6 pol toggle sets", 32'(flag_o), 3'b100);
    wr(0); pol = 0; cyc(2); chk("R6 pol back sets", 32'(flag_o), 3'b100);
    wr(0); cyc(2);

    // R7/R8 sticky, force, clear
    cur_tag = "R8"; wr(3'b011); chk("R8 forced", 32'(flag_o), 3'b011);
    cur_tag = "R7"; cyc(5); chk("R7 sticky", 32'(flag_o), 3'b011);
    wr(3'b001); chk("R7 clear one", 32'(flag_o), 3'b001);
    wr(0); chk("R7 clear all", 32'(flag_o), 0);

    // R9: event and clear in the same cycle
    cur_tag = "R9"; mode = 6'b11_11_11; cyc(2);
    @(negedge clk); pol = 3'b010; flag_wr_en = 1; flag_wr_data = 0;
    @(negedge clk); flag_wr_en = 0;
    chk("R9 hw set wins", 32'(flag_o), 3'b010);
    pol = 0; cyc(2); wr(0);

    // R11/R10: latch with enables off, then enable combos
    cur_tag = "R11"; ch_en = 0; periph_en = 0; global_en = 0;
    cmp_raw = 3'b001; cyc(4); chk("R11 latched masked", 32'(flag_o), 1);
    chk("R11 irq low", 32'(irq_o), 0);
    cur_tag = "R10";
    ch_en = 3'b001; cyc(1); chk("R10 no periph", 32'(irq_o), 0);
    periph_en = 1; cyc(1); chk("R10 no global", 32'(irq_o), 0);
    global_en = 1; #1; chk("R10 all on", 32'(irq_o), 1);
    ch_en = 3'b110; #1; chk("R10 wrong channel", 32'(irq_o), 0);
    wr(0); cmp_raw = 0; cyc(4); wr(0);

    // constrained random mix
    cur_tag = "Rmix";
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk);
      if ($urandom_range(0, 3) == 0) cmp_raw = NCH'($urandom);
      if ($urandom_range(0, 15) == 0) pol = NCH'($urandom);
      if ($urandom_range(0, 31) == 0) mode = (2*NCH)'($urandom);
      flag_wr_en = ($urandom_range(0, 9) == 0);
      flag_wr_data = NCH'($urandom);
      if ($urandom_range(0, 19) == 0) begin
        ch_en = NCH'($urandom); periph_en = 1'($urandom); global_en = 1'($urandom);
      end
    end
    @(negedge clk); flag_wr_en = 0;
    cyc(4);
    cmp_on = 0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule